// File: doc/BRIEF.md
# Partial-Word Store Byte-Lane Unit

This unit turns a partial-word store request into a single aligned write on a word-wide memory port. A request carries a byte address, a register value and a mode bit. In begin mode the unit writes from the addressed byte up to the last byte of the word, taking the low-order bytes of the value. In end mode it writes the bytes that come before the addressed byte, taking the high-order bytes of the value.

Byte order is big-endian: byte 0 of a word is the most significant lane. The unit presents the write as a word-aligned address, a byte-enable mask, and data already shifted into its lanes. Because each store is one masked word write, a three-byte store reaches memory as a single transaction and cannot be split.

An end-mode store to an aligned address writes no bytes. It is still issued as a transaction with an empty mask and a probe flag, so that the memory side can run its protection check and mark the line dirty. The request is held until the port accepts it, and a one-cycle completion pulse follows the acceptance.

Top module: `pstore_lane_unit`

## Requirements
- R1: In begin mode (`req_end`=0) with byte offset o = `req_addr[1:0]`, the enabled bytes are o through 3. Byte k of the word is lane `mem_wdata[31-8k -: 8]` and is flagged by `mem_be[3-k]`. Each enabled lane carries the same lane of `req_data`, so only the low-order 4-o bytes of the value are written.
- R2: In end mode (`req_end`=1) with offset 1, 2 or 3, the enabled bytes are 0 through o-1. They carry the high-order o bytes of `req_data` in their own lanes.
- R3: An end-mode request with offset 0 produces a transaction with `mem_be`=0 and `mem_probe`=1. Every other request produces `mem_probe`=0 and a nonzero mask.
- R4: `mem_addr` equals `req_addr` with its two low bits cleared.
- R5: Every lane whose enable bit is 0 carries zero data.
- R6: Each accepted request yields exactly one handshake (`mem_valid` and `mem_ready` high at a clock edge), including three-byte stores. `mem_valid` rises in the cycle after acceptance and falls in the cycle after the handshake.
- R7: While `mem_valid` is high and `mem_ready` is low, `mem_addr`, `mem_be`, `mem_wdata` and `mem_probe` do not change.
- R8: `done` is high for exactly one cycle, the cycle after the handshake, and is low at all other times.
- R9: `req_ready` is high exactly when no write is pending. A request presented while `req_ready` is low is ignored. After reset, `mem_valid`=0, `done`=0 and `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Store request present |
| req_ready | output | 1 | Unit can take a request |
| req_addr | input | ADDR_W | Byte address of the store |
| req_data | input | DATA_W | Register value to store |
| req_end | input | 1 | 0 = begin mode, 1 = end mode |
| mem_valid | output | 1 | Write transaction pending |
| mem_ready | input | 1 | Memory accepts the transaction |
| mem_addr | output | ADDR_W | Word-aligned write address |
| mem_be | output | DATA_W/8 | Byte enables, bit 3 = byte 0 |
| mem_wdata | output | DATA_W | Lane-aligned write data |
| mem_probe | output | 1 | Zero-length probe transaction |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the unit with its defaults: a 32-bit address and a 32-bit data word. Random upper address bits therefore exercise the alignment clear over the whole address range, and all eight combinations of mode and offset can be reached. Each of these combinations is driven directly with and without memory back-pressure. A random mix follows in which a stray request is presented during a stall, which checks that pending writes are held and that requests arriving while busy are ignored.

// File: rtl/pstore_lane_unit.sv
module pstore_lane_unit #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_data,
  input  logic                req_end,
  output logic                mem_valid,
  input  logic                mem_ready,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W/8-1:0] mem_be,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic                mem_probe,
  output logic                done
);
  localparam int NB    = DATA_W / 8;
  localparam int OFF_W = $clog2(NB);

  logic [OFF_W-1:0]  off;
  logic [NB-1:0]     lane_en;
  logic [DATA_W-1:0] lane_data;
  logic              accept;

  assign off       = req_addr[OFF_W-1:0];
  assign req_ready = !mem_valid;
  assign accept    = req_valid && req_ready;

  for (genvar k = 0; k < NB; k++) begin : g_lane
    assign lane_en[NB-1-k] = req_end ? (OFF_W'(k) < off) : (OFF_W'(k) >= off);
    assign lane_data[DATA_W-1-8*k -: 8] =
      lane_en[NB-1-k] ? req_data[DATA_W-1-8*k -: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_wdata <= '0;
      mem_probe <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= mem_valid && mem_ready;
      if (accept) begin
        mem_valid <= 1'b1;
        mem_addr  <= {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        mem_be    <= lane_en;
        mem_wdata <= lane_data;
        mem_probe <= req_end && (off == '0);
      end else if (mem_valid && mem_ready) begin
        mem_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pstore_lane_unit_sva.sv
module pstore_lane_unit_sva #(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_ready,
  input logic                mem_valid,
  input logic                mem_ready,
  input logic [OFF_W-1:0]    addr_lo,
  input logic [DATA_W/8-1:0] mem_be,
  input logic [DATA_W-1:0]   mem_wdata,
  input logic                mem_probe,
  input logic                done
);
  localparam int NB = DATA_W / 8;

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> addr_lo == '0); // R4
  AST_PROBE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_probe |-> mem_be == '0); // R3
  AST_WRITE_HAS_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_probe |-> mem_be != '0); // R3
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(addr_lo) && $stable(mem_be)
      && $stable(mem_wdata) && $stable(mem_probe)); // R7
  AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready |=> done && !mem_valid); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !req_ready); // R9

  for (genvar k = 0; k < NB; k++) begin : g_zero
    AST_IDLE_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && !mem_be[NB-1-k] |-> mem_wdata[DATA_W-1-8*k -: 8] == 8'h00); // R5
  end
endmodule

bind pstore_lane_unit pstore_lane_unit_sva #(.DATA_W(DATA_W), .OFF_W(OFF_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .mem_valid(mem_valid),
  .mem_ready(mem_ready), .addr_lo(mem_addr[OFF_W-1:0]), .mem_be(mem_be),
  .mem_wdata(mem_wdata), .mem_probe(mem_probe), .done(done)
);

// File: tb/pstore_lane_unit_tb_top.sv
module pstore_lane_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [31:0] req_data = '0;
  logic        req_end = 1'b0;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic        mem_probe;
  logic        done;

  int n_chk = 0, n_fail = 0, hs = 0;

  always #4 clk = ~clk;

  pstore_lane_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_end(req_end),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_probe(mem_probe), .done(done)
  );

  always @(posedge clk) if (rst_n && mem_valid && mem_ready) hs++;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_be(input logic [1:0] o, input bit e);
    logic [3:0] m = '0;
    for (int k = 0; k < 4; k++)
      m[3-k] = e ? (k < int'(o)) : (k >= int'(o));
    return m;
  endfunction

  function automatic logic [31:0] exp_data(input logic [31:0] d, input logic [3:0] m);
    logic [31:0] r = '0;
    for (int k = 0; k < 4; k++)
      if (m[3-k]) r[31-8*k -: 8] = d[31-8*k -: 8];
    return r;
  endfunction

  task automatic check_out(input logic [31:0] a, input logic [3:0] eb,
                           input logic [31:0] ed, input bit ep, input string rq);
    chk(mem_valid == 1'b1, "R6", "mem_valid", 64'(mem_valid), 64'd1);
    chk(mem_addr == {a[31:2], 2'b00}, "R4", "mem_addr", 64'(mem_addr), 64'({a[31:2], 2'b00}));
    chk(mem_be == eb, rq, "mem_be", 64'(mem_be), 64'(eb));
    chk(mem_wdata == ed, "R5", "mem_wdata", 64'(mem_wdata), 64'(ed));
    chk(mem_probe == ep, "R3", "mem_probe", 64'(mem_probe), 64'(ep));
  endtask

  task automatic run(input logic [31:0] a, input logic [31:0] d, input bit e, input int stall);
    logic [3:0]  eb = exp_be(a[1:0], e);
    logic [31:0] ed = exp_data(d, eb);
    bit          ep = e && (a[1:0] == 2'b00);
    string       rq = ep ? "R3" : (e ? "R2" : "R1");
    int          hs0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9", "req_ready idle", 64'(req_ready), 64'd1);
    req_addr = a; req_data = d; req_end = e; req_valid = 1'b1; mem_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    check_out(a, eb, ed, ep, rq);
    hs0 = hs;
    for (int i = 0; i < stall; i++) begin
      chk(req_ready == 1'b0, "R9", "req_ready busy", 64'(req_ready), 64'd0);
      if (i == 0) begin
        req_addr = ~a; req_data = ~d; req_end = ~e; req_valid = 1'b1;
      end
      @(negedge clk);
      req_valid = 1'b0;
      check_out(a, eb, ed, ep, "R7");
      chk(done == 1'b0, "R8", "done during stall", 64'(done), 64'd0);
    end
    mem_ready = 1'b1;
    @(negedge clk);
    mem_ready = 1'b0;
    chk(mem_valid == 1'b0, "R6", "mem_valid after handshake", 64'(mem_valid), 64'd0);
    chk(done == 1'b1, "R8", "done pulse", 64'(done), 64'd1);
    chk(hs == hs0 + 1, "R6", "handshake count", 64'(hs), 64'(hs0 + 1));
    @(negedge clk);
    chk(done == 1'b0, "R8", "done cleared", 64'(done), 64'd0);
    chk(mem_valid == 1'b0, "R9", "ignored busy request", 64'(mem_valid), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    chk(mem_valid == 1'b0, "R9", "reset mem_valid", 64'(mem_valid), 64'd0);
    chk(done == 1'b0, "R9", "reset done", 64'(done), 64'd0);
    chk(req_ready == 1'b1, "R9", "reset req_ready", 64'(req_ready), 64'd1);
    rst_n = 1'b1;
    for (int m = 0; m < 2; m++)
      for (int o = 0; o < 4; o++) begin
        run({30'h1234_5678 >> 2, 2'(o)}, 32'hA1B2_C3D4, m[0], 0);
        run({30'h3FFF_FFFF, 2'(o)}, 32'hFFFF_FFFF, m[0], 2);
      end
    for (int i = 0; i < 150; i++)
      run($urandom, $urandom, 1'($urandom), int'($urandom % 3));
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule